// File: doc/BRIEF.md
# Byte Table Shuffle Blend Unit

This block is a 128-bit rearrangement datapath. It selects bytes from a data vector by run-time index, or it combines two operand vectors element by element. A 2-bit operation code picks one of four functions. The first is a 16-lane byte lookup, where every control byte either names a source byte or asks for a zero. The second is the same lookup on the low 64 bits only, with 3-bit indices. The third is a blend steered by an immediate bitmask. The fourth is a blend steered by the sign bit of each element of a third vector.

A separate 2-bit size code sets the element granularity of the two blends. The result and its valid flag are registered, so the answer appears one cycle after the request. The captured result stays on the output until the next accepted request.

Top module: `bsb_unit`

## Requirements
- R1: With `op` = 2'b00 (full shuffle), result byte k is zero whenever bit 7 of control byte k (`src_b[8k+7]`) is 1.
- R2: With `op` = 2'b00 and bit 7 of control byte k clear, result byte k equals byte `src_b[8k+3:8k]` of `src_a`. Control bits [6:4] have no effect on the result.
- R3: With `op` = 2'b01 (half shuffle), result bytes 0..7 follow the bit-7 zeroing rule. Otherwise they take byte `src_b[8k+2:8k]` of the low 64 bits of `src_a`, with control bits [6:3] ignored. Result bits [127:64] are zero.
- R4: With `op` = 2'b10 (immediate blend), element j is taken from `src_b` when `imm[j]` is 1 and from `src_a` when it is 0. Element size follows `esz`: 2'b00 gives eight 16-bit elements (imm[7:0]), 2'b01 gives four 32-bit elements (imm[3:0]), and 2'b10 or 2'b11 gives two 64-bit elements (imm[1:0]). Imm bits above the element count are ignored.
- R5: With `op` = 2'b11 (mask blend), element j is taken from `src_b` when the most significant bit of element j of `src_m` is 1, else from `src_a`. Element size follows `esz`: 2'b00 gives 8-bit elements, 2'b01 gives 32-bit elements, and 2'b10 or 2'b11 gives 64-bit elements. All other mask bits are ignored.
- R6: `out_valid` is high in exactly the cycles that follow a rising clock edge at which `in_valid` was high. `out_data` then carries the result of that request.
- R7: When `in_valid` is low at a clock edge, `out_data` keeps its previous value, whatever the other inputs are.
- R8: While `rst_n` is low, `out_valid` and `out_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; inputs are captured when high |
| op | input | 2 | Function: 00 full shuffle, 01 half shuffle, 10 immediate blend, 11 mask blend |
| esz | input | 2 | Blend element size code |
| imm | input | 8 | Immediate blend bitmask |
| src_a | input | 128 | Data table for shuffles; first blend operand |
| src_b | input | 128 | Per-byte control for shuffles; second blend operand |
| src_m | input | 128 | Sign-bit mask vector for the mask blend |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_data | output | 128 | Registered result |

## Verification
The cases hardest to reach are those where bits that must be ignored carry ones. Examples are control bytes with bits [6:4] (or [6:3] in the half shuffle) set while the zero bit is clear, mask vectors whose non-sign bits oppose their sign bits, and immediates whose unused upper bits are set. Random data hides these cases, because a wrong decode can still land on the right byte by chance. Directed vectors therefore pair a permutation of distinct byte values with control bytes that carry the ignored bits. Random requests mixed with idle cycles, where inputs change freely, then cover the holding and valid timing.

// File: rtl/bsb_pkg.sv
package bsb_pkg;

   typedef enum logic [1:0] {
      OP_SHUF_FULL = 2'b00,
      OP_SHUF_HALF = 2'b01,
      OP_BLEND_IMM = 2'b10,
      OP_BLEND_VAR = 2'b11
   } bsb_op_e;

   typedef enum logic [1:0] {
      ESZ_NARROW = 2'b00,
      ESZ_DWORD  = 2'b01,
      ESZ_QWORD  = 2'b10,
      ESZ_QWIDE  = 2'b11
   } bsb_esz_e;

endpackage

// File: rtl/bsb_byte_shuffle.sv
module bsb_byte_shuffle #(
   parameter int LANES  = 16,
   parameter int BYTE_W = 8
) (
   input  logic [LANES*BYTE_W-1:0] table_i,
   input  logic [LANES*BYTE_W-1:0] ctrl_i,
   output logic [LANES*BYTE_W-1:0] res_o
);
   localparam int IDX_W = $clog2(LANES);

   if ((LANES < 2) || ((LANES & (LANES - 1)) != 0)) begin : g_bad_lanes
      $error("bsb_byte_shuffle: LANES must be a power of two");
   end
   if (IDX_W >= BYTE_W) begin : g_bad_width
      $error("bsb_byte_shuffle: index field overlaps zeroing bit");
   end

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [IDX_W-1:0] idx;
      logic             kill;
      logic             unused_hi;

      assign idx       = ctrl_i[j*BYTE_W +: IDX_W];
      assign kill      = ctrl_i[j*BYTE_W + BYTE_W - 1];
      assign unused_hi = ^ctrl_i[j*BYTE_W + IDX_W +: BYTE_W - 1 - IDX_W];
      assign res_o[j*BYTE_W +: BYTE_W] =
         kill ? '0 : table_i[idx*BYTE_W +: BYTE_W];
   end

endmodule

// File: rtl/bsb_blend.sv
module bsb_blend
   import bsb_pkg::*;
#(
   parameter int LANES  = 16,
   parameter int BYTE_W = 8
) (
   input  logic [LANES*BYTE_W-1:0] a_i,
   input  logic [LANES*BYTE_W-1:0] b_i,
   input  logic [LANES*BYTE_W-1:0] m_i,
   input  logic [LANES/2-1:0]      imm_i,
   input  logic                    use_mask_i,
   input  bsb_esz_e                esz_i,
   output logic [LANES*BYTE_W-1:0] res_o
);
   localparam int DW_BYTES = 4;
   localparam int QW_BYTES = 8;

   if ((LANES % QW_BYTES) != 0) begin : g_bad_lanes
      $error("bsb_blend: LANES must be a multiple of eight");
   end

   logic [LANES-1:0] take_b;
   logic             unused_mask;

   assign unused_mask = ^m_i;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic pick_imm;
      logic pick_var;

      always_comb begin
         unique case (esz_i)
            ESZ_NARROW: begin
               pick_imm = imm_i[k/2];
               pick_var = m_i[k*BYTE_W + BYTE_W - 1];
            end
            ESZ_DWORD: begin
               pick_imm = imm_i[k/DW_BYTES];
               pick_var = m_i[(k/DW_BYTES)*DW_BYTES*BYTE_W + DW_BYTES*BYTE_W - 1];
            end
            default: begin
               pick_imm = imm_i[k/QW_BYTES];
               pick_var = m_i[(k/QW_BYTES)*QW_BYTES*BYTE_W + QW_BYTES*BYTE_W - 1];
            end
         endcase
      end

      assign take_b[k] = use_mask_i ? pick_var : pick_imm;
      assign res_o[k*BYTE_W +: BYTE_W] =
         take_b[k] ? b_i[k*BYTE_W +: BYTE_W] : a_i[k*BYTE_W +: BYTE_W];
   end

endmodule

// File: rtl/bsb_out_stage.sv
module bsb_out_stage #(
   parameter int W = 128
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] data_i,
   output logic         valid_o,
   output logic [W-1:0] data_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         data_o  <= '0;
      end else begin
         valid_o <= load_i;
         if (load_i) begin
            data_o <= data_i;
         end
      end
   end

endmodule

// File: rtl/bsb_unit.sv
module bsb_unit
   import bsb_pkg::*;
#(
   parameter int LANES  = 16,
   parameter int BYTE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [1:0]              op,
   input  logic [1:0]              esz,
   input  logic [LANES/2-1:0]      imm,
   input  logic [LANES*BYTE_W-1:0] src_a,
   input  logic [LANES*BYTE_W-1:0] src_b,
   input  logic [LANES*BYTE_W-1:0] src_m,
   output logic                    out_valid,
   output logic [LANES*BYTE_W-1:0] out_data
);
   localparam int W      = LANES * BYTE_W;
   localparam int HALF_L = LANES / 2;
   localparam int HALF_W = HALF_L * BYTE_W;

   if (LANES < 8) begin : g_bad_lanes
      $error("bsb_unit: at least eight lanes are required");
   end

   logic [W-1:0]      full_res;
   logic [HALF_W-1:0] half_res;
   logic [W-1:0]      blend_res;
   logic [W-1:0]      next_res;
   bsb_op_e           op_e;

   assign op_e = bsb_op_e'(op);

   bsb_byte_shuffle #(
      .LANES (LANES),
      .BYTE_W(BYTE_W)
   ) u_shuf_full (
      .table_i(src_a),
      .ctrl_i (src_b),
      .res_o  (full_res)
   );

   bsb_byte_shuffle #(
      .LANES (HALF_L),
      .BYTE_W(BYTE_W)
   ) u_shuf_half (
      .table_i(src_a[HALF_W-1:0]),
      .ctrl_i (src_b[HALF_W-1:0]),
      .res_o  (half_res)
   );

   bsb_blend #(
      .LANES (LANES),
      .BYTE_W(BYTE_W)
   ) u_blend (
      .a_i       (src_a),
      .b_i       (src_b),
      .m_i       (src_m),
      .imm_i     (imm),
      .use_mask_i(op_e == OP_BLEND_VAR),
      .esz_i     (bsb_esz_e'(esz)),
      .res_o     (blend_res)
   );

   always_comb begin
      unique case (op_e)
         OP_SHUF_FULL: next_res = full_res;
         OP_SHUF_HALF: next_res = {{(W-HALF_W){1'b0}}, half_res};
         default:      next_res = blend_res;
      endcase
   end

   bsb_out_stage #(
      .W(W)
   ) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (in_valid),
      .data_i (next_res),
      .valid_o(out_valid),
      .data_o (out_data)
   );

endmodule

// File: rtl/bsb_unit_chk.sv
module bsb_unit_chk #(
   parameter int LANES  = 16,
   parameter int BYTE_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic [1:0]              op,
   input logic [1:0]              esz,
   input logic [LANES/2-1:0]      imm,
   input logic [LANES*BYTE_W-1:0] src_a,
   input logic [LANES*BYTE_W-1:0] src_b,
   input logic [LANES*BYTE_W-1:0] src_m,
   input logic                    out_valid,
   input logic [LANES*BYTE_W-1:0] out_data
);
   localparam int W = LANES * BYTE_W;

   p_valid_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_valid == $past(in_valid)));

   p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(in_valid)) |-> $stable(out_data));

   p_half_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid) && ($past(op) == 2'b01))
      |-> (out_data[W-1:W/2] == '0));

   p_lane0_kill_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid) && ($past(op) == 2'b00) && $past(src_b[BYTE_W-1]))
      |-> (out_data[BYTE_W-1:0] == '0));

   p_imm_all_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid) && ($past(op) == 2'b10) &&
       ($past(esz) == 2'b00) && $past(&imm))
      |-> (out_data == $past(src_b)));

   p_mask_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid) && ($past(op) == 2'b11) && ($past(src_m) == '0))
      |-> (out_data == $past(src_a)));

endmodule

bind bsb_unit bsb_unit_chk #(
   .LANES (LANES),
   .BYTE_W(BYTE_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .op       (op),
   .esz      (esz),
   .imm      (imm),
   .src_a    (src_a),
   .src_b    (src_b),
   .src_m    (src_m),
   .out_valid(out_valid),
   .out_data (out_data)
);

// File: tb/sim_bsb_unit.sv
`timescale 1ns/1ps
module sim_bsb_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   op = 2'b00;
   logic [1:0]   esz = 2'b00;
   logic [7:0]   imm = 8'h00;
   logic [127:0] src_a = '0;
   logic [127:0] src_b = '0;
   logic [127:0] src_m = '0;
   logic         out_valid;
   logic [127:0] out_data;

   int errors = 0;
   int checks = 0;
   logic [127:0] exp_q[$];
   string        tag_q[$];
   logic         prev_in_valid = 1'b0;
   logic         seen_any = 1'b0;
   logic [127:0] last_data = '0;

   always #10 clk = ~clk;

   bsb_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .esz(esz),
      .imm(imm), .src_a(src_a), .src_b(src_b), .src_m(src_m),
      .out_valid(out_valid), .out_data(out_data)
   );

   function automatic logic [127:0] rnd128();
      return {$urandom(), $urandom(), $urandom(), $urandom()};
   endfunction

   function automatic logic [127:0] model(input logic [1:0] f, input logic [1:0] sz,
                                          input logic [7:0] im, input logic [127:0] a,
                                          input logic [127:0] b, input logic [127:0] m);
      logic [127:0] r;
      logic [7:0]   c;
      logic         pick;
      r = '0;
      for (int k = 0; k < 16; k++) begin
         c = b[8*k +: 8];
         pick = 1'b0;
         case (f)
            2'b00: r[8*k +: 8] = c[7] ? 8'h00 : a[8*c[3:0] +: 8];
            2'b01: if (k < 8) r[8*k +: 8] = c[7] ? 8'h00 : a[8*c[2:0] +: 8];
            2'b10: begin
               pick = (sz == 2'b00) ? im[k/2] : (sz == 2'b01) ? im[k/4] : im[k/8];
               r[8*k +: 8] = pick ? b[8*k +: 8] : a[8*k +: 8];
            end
            default: begin
               pick = (sz == 2'b00) ? m[8*k+7] : (sz == 2'b01) ? m[32*(k/4)+31] : m[64*(k/8)+63];
               r[8*k +: 8] = pick ? b[8*k +: 8] : a[8*k +: 8];
            end
         endcase
      end
      return r;
   endfunction

   task automatic drive(input string tag, input logic [1:0] f, input logic [1:0] sz,
                        input logic [7:0] im, input logic [127:0] a,
                        input logic [127:0] b, input logic [127:0] m);
      @(posedge clk);
      #2;
      in_valid = 1'b1; op = f; esz = sz; imm = im;
      src_a = a; src_b = b; src_m = m;
      exp_q.push_back(model(f, sz, im, a, b, m));
      tag_q.push_back(tag);
   endtask

   task automatic idle();
      @(posedge clk);
      #2;
      in_valid = 1'b0;
      op = 2'($urandom()); esz = 2'($urandom()); imm = 8'($urandom());
      src_a = rnd128(); src_b = rnd128(); src_m = rnd128();
   endtask

   // Monitor: pops the scoreboard on each valid result.
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (out_valid != prev_in_valid) begin
            errors++;
            $display("FAIL R6: out_valid=%0b expected %0b", out_valid, prev_in_valid);
         end
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL R6: result with empty scoreboard, got %h expected none", out_data);
            end else begin
               logic [127:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               checks++;
               if (out_data !== e) begin
                  errors++;
                  $display("FAIL %s: got %h expected %h", t, out_data, e);
               end
            end
            seen_any = 1'b1;
            last_data = out_data;
         end else if (seen_any) begin
            checks++;
            if (out_data !== last_data) begin
               errors++;
               $display("FAIL R7: idle changed data, got %h expected %h", out_data, last_data);
            end
         end
      end
      prev_in_valid = in_valid && rst_n;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      logic [127:0] tbl, ctl, mk;
      // R8: reset state
      repeat (3) @(posedge clk);
      #5;
      checks++;
      if (out_valid !== 1'b0 || out_data !== '0) begin
         errors++;
         $display("FAIL R8: got valid=%0b data=%h expected 0/0", out_valid, out_data);
      end
      @(posedge clk); #2; rst_n = 1'b1;

      for (int k = 0; k < 16; k++) tbl[8*k +: 8] = 8'hA0 + 8'(k);

      // R1: all zero requests, then alternating kill/index
      for (int k = 0; k < 16; k++) ctl[8*k +: 8] = 8'h80 | 8'(k);
      drive("R1", 2'b00, 2'b00, 8'h00, tbl, ctl, '0);
      for (int k = 0; k < 16; k++) ctl[8*k +: 8] = (k % 2 == 0) ? 8'hFF : 8'(15 - k);
      drive("R1", 2'b00, 2'b00, 8'h00, tbl, ctl, '0);
      // R2: reversal with ignored bits [6:4] set
      for (int k = 0; k < 16; k++) ctl[8*k +: 8] = 8'h70 | 8'(15 - k);
      drive("R2", 2'b00, 2'b00, 8'h00, tbl, ctl, '0);
      for (int k = 0; k < 16; k++) ctl[8*k +: 8] = 8'h50 | 8'((k * 5) % 16);
      drive("R2", 2'b00, 2'b00, 8'h00, tbl, ctl, '0);
      // R3: half shuffle, bits [6:3] set, upper half random
      ctl = rnd128();
      for (int k = 0; k < 8; k++) ctl[8*k +: 8] = (k == 3) ? 8'h80 : (8'h78 | 8'(7 - k));
      drive("R3", 2'b01, 2'b00, 8'h00, tbl, ctl, '0);
      idle();
      // R4: immediate blend at every size, unused imm bits set
      drive("R4", 2'b10, 2'b00, 8'hA5, rnd128(), rnd128(), '0);
      drive("R4", 2'b10, 2'b01, 8'hF6, rnd128(), rnd128(), '0);
      drive("R4", 2'b10, 2'b10, 8'hFE, rnd128(), rnd128(), '0);
      drive("R4", 2'b10, 2'b11, 8'h01, rnd128(), rnd128(), '0);
      // R5: mask blend, non-sign bits opposite to sign bits
      for (int k = 0; k < 16; k++) mk[8*k +: 8] = (k % 3 == 0) ? 8'h80 : 8'h7F;
      drive("R5", 2'b11, 2'b00, 8'h00, rnd128(), rnd128(), mk);
      mk = {32'h7FFF_FFFF, 32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF};
      drive("R5", 2'b11, 2'b01, 8'h00, rnd128(), rnd128(), mk);
      mk = {64'h0000_0000_0000_0000 | 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000};
      drive("R5", 2'b11, 2'b10, 8'h00, rnd128(), rnd128(), mk);
      drive("R5", 2'b11, 2'b11, 8'hFF, rnd128(), rnd128(), ~mk);
      idle(); idle();
      // R6/R7: random mix of requests and idle gaps
      for (int n = 0; n < 400; n++) begin
         if ($urandom_range(0, 3) == 0) idle();
         else begin
            logic [1:0] f;
            f = 2'($urandom());
            case (f)
               2'b00: drive("R2", f, 2'($urandom()), 8'($urandom()), rnd128(), rnd128(), rnd128());
               2'b01: drive("R3", f, 2'($urandom()), 8'($urandom()), rnd128(), rnd128(), rnd128());
               2'b10: drive("R4", f, 2'($urandom()), 8'($urandom()), rnd128(), rnd128(), rnd128());
               default: drive("R5", f, 2'($urandom()), 8'($urandom()), rnd128(), rnd128(), rnd128());
            endcase
         end
      end
      idle(); idle(); idle();
      @(posedge clk); #5;
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R6: %0d results missing, expected 0", exp_q.size());
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule